// File: doc/BRIEF.md
# Auxiliary ADC Window Threshold Monitor

This block compares a stream of converter samples against a programmable window. A host loads a single threshold register that carries an upper and a lower limit. The block compares each valid sample with both limits. A sample strictly above the upper limit latches an "over" flag. A sample strictly below the lower limit latches an "under" flag. Both flags stay set until the host reads the status port, and that read clears them.

A separate interrupt-enable register selects which flags drive the level-sensitive interrupt output. While the converter enable input is high, the block ignores writes to the threshold register so the limits cannot change during a conversion run. It does not define what happens when the upper limit is below the lower one. It still evaluates each comparison on its own, and it never stalls.

Top module: `aux_window_monitor`

## Requirements
- R1: A write with `reg_sel`=0 loads the upper limit from `reg_wdata[15:8]` and the lower limit from `reg_wdata[7:0]`.
- R2: On a cycle with `sample_vld`=1 and `sample` strictly greater than the upper limit, the over flag (`stat_rdata[1]`) reads 1 from the next cycle.
- R3: On a cycle with `sample_vld`=1 and `sample` strictly less than the lower limit, the under flag (`stat_rdata[0]`) reads 1 from the next cycle.
- R4: A sample equal to a limit sets no flag, and a sample presented with `sample_vld`=0 sets no flag.
- R5: Flags stay set until a read. `stat_rdata` shows the flags during the cycle in which `stat_rd`=1, and both flags are 0 from the next cycle.
- R6: If a crossing arrives in the same cycle as a read, its flag stays set after the read.
- R7: A write with `reg_sel`=1 loads the interrupt enables: bit 1 enables the over flag and bit 0 enables the under flag. `irq` is the OR of each flag ANDed with its enable, and it falls after the read that clears the flags.
- R8: Threshold writes made while `adc_en`=1 are ignored and the held limits stay unchanged. Writes to the interrupt enables are accepted whatever the state of `adc_en`.
- R9: If the upper limit is below the lower limit, each comparison still acts on its own, and one sample may set both flags.
- R10: After reset, both limits, both flags, both enables and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 thresholds, 1 interrupt enables |
| reg_wdata | input | 16 | Write data |
| adc_en | input | 1 | Converter enable; locks out threshold writes |
| sample_vld | input | 1 | Sample valid pulse |
| sample | input | 8 | Converter sample value |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_rdata | output | 2 | Flags: bit 1 over, bit 0 under |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is stable and known at each rising edge and that `stat_rd` is a single-cycle strobe. They do not assume that the upper limit is at least the lower one, so inverted windows are exercised too. The bench changes inputs only just after a clock edge, and it holds `sample_vld` and `stat_rd` high for one cycle at a time. Threshold writes it expects to take effect are made with `adc_en` low. Locked-out writes are made on purpose with `adc_en` high.

// File: rtl/aux_mon_pkg.sv
package aux_mon_pkg;
  typedef enum logic {
    SEL_THR = 1'b0,
    SEL_IEN = 1'b1
  } reg_sel_e;

  localparam int FLAG_UNDER = 0;
  localparam int FLAG_OVER  = 1;
  localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/aux_thr_regs.sv
module aux_thr_regs
  import aux_mon_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  localparam int REG_W   = 2 * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  reg_sel_e             reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 adc_en,
  output logic [SAMPLE_W-1:0]  thr_hi,
  output logic [SAMPLE_W-1:0]  thr_lo,
  output logic [NUM_FLAGS-1:0] ien
);
  logic thr_req;
  logic thr_load;
  logic thr_blocked;
  logic ien_load;

  assign thr_req     = reg_wr && (reg_sel == SEL_THR);
  assign thr_load    = thr_req && !adc_en;
  assign thr_blocked = thr_req && adc_en;
  assign ien_load    = reg_wr && (reg_sel == SEL_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi <= '0;
      thr_lo <= '0;
    end else if (thr_load) begin
      thr_hi <= reg_wdata[REG_W-1:SAMPLE_W];
      thr_lo <= reg_wdata[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien <= '0;
    else if (ien_load) ien <= reg_wdata[NUM_FLAGS-1:0];
  end

  // R8
  thr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_blocked |=> $stable({thr_hi, thr_lo}));

  // R1
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_load |=> ({thr_hi, thr_lo} == $past(reg_wdata)));
endmodule

// File: rtl/aux_window_cmp.sv
module aux_window_cmp
  import aux_mon_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_vld,
  input  logic [SAMPLE_W-1:0]  sample,
  input  logic [SAMPLE_W-1:0]  thr_hi,
  input  logic [SAMPLE_W-1:0]  thr_lo,
  output logic [NUM_FLAGS-1:0] hit
);
  function automatic logic above(input logic [SAMPLE_W-1:0] val,
                                 input logic [SAMPLE_W-1:0] lim);
    return val > lim;
  endfunction

  function automatic logic below(input logic [SAMPLE_W-1:0] val,
                                 input logic [SAMPLE_W-1:0] lim);
    return val < lim;
  endfunction

  logic over_evt;
  logic under_evt;

  assign over_evt  = sample_vld && above(sample, thr_hi);
  assign under_evt = sample_vld && below(sample, thr_lo);

  always_comb begin
    hit             = '0;
    hit[FLAG_OVER]  = over_evt;
    hit[FLAG_UNDER] = under_evt;
  end

  // R4
  no_hit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |-> (hit == '0));

  // R4
  eq_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample == thr_hi && sample == thr_lo) |-> (hit == '0));
endmodule

// File: rtl/aux_status_flags.sv
module aux_status_flags
  import aux_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] hit,
  input  logic                 stat_rd,
  input  logic [NUM_FLAGS-1:0] ien,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit[i])   flag_q <= 1'b1;
      else if (stat_rd)  flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;

    // R2 R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i]);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !stat_rd) |=> flags[i]);

    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !hit[i]) |=> !flags[i]);
  end

  assign irq = |(flags & ien);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(stat_rd) || !$stable(ien)));
endmodule

// File: rtl/aux_window_monitor.sv
module aux_window_monitor
  import aux_mon_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  localparam int REG_W   = 2 * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 adc_en,
  input  logic                 sample_vld,
  input  logic [SAMPLE_W-1:0]  sample,
  input  logic                 stat_rd,
  output logic [NUM_FLAGS-1:0] stat_rdata,
  output logic                 irq
);
  logic [SAMPLE_W-1:0]  thr_hi;
  logic [SAMPLE_W-1:0]  thr_lo;
  logic [NUM_FLAGS-1:0] ien;
  logic [NUM_FLAGS-1:0] hit;
  logic [NUM_FLAGS-1:0] flags;

  aux_thr_regs #(.SAMPLE_W(SAMPLE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel_e'(reg_sel)),
    .reg_wdata (reg_wdata),
    .adc_en    (adc_en),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .ien       (ien)
  );

  aux_window_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .sample     (sample),
    .thr_hi     (thr_hi),
    .thr_lo     (thr_lo),
    .hit        (hit)
  );

  aux_status_flags u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .stat_rd (stat_rd),
    .ien     (ien),
    .flags   (flags),
    .irq     (irq)
  );

  assign stat_rdata = flags;

  // R6
  rd_race_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && hit[FLAG_OVER]) |=> stat_rdata[FLAG_OVER]);

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata == '0) |-> !irq);
endmodule

// File: tb/aux_window_monitor_tb_top.sv
module aux_window_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        adc_en = 1'b0;
  logic        sample_vld = 1'b0;
  logic [7:0]  sample = '0;
  logic        stat_rd = 1'b0;
  logic [1:0]  stat_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  aux_window_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .adc_en(adc_en), .sample_vld(sample_vld),
    .sample(sample), .stat_rd(stat_rd), .stat_rdata(stat_rdata), .irq(irq)
  );

  // {upper, lower, sample, expected {over,under}}
  localparam int NVEC = 12;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'd200, 8'd50,  8'd100, 2'b00},
    {8'd200, 8'd50,  8'd201, 2'b10},
    {8'd200, 8'd50,  8'd200, 2'b00},
    {8'd200, 8'd50,  8'd50,  2'b00},
    {8'd200, 8'd50,  8'd49,  2'b01},
    {8'd255, 8'd0,   8'd255, 2'b00},
    {8'd255, 8'd0,   8'd0,   2'b00},
    {8'd128, 8'd128, 8'd128, 2'b00},
    {8'd128, 8'd128, 8'd129, 2'b10},
    {8'd128, 8'd128, 8'd127, 2'b01},
    {8'd0,   8'd255, 8'd128, 2'b11},
    {8'd10,  8'd20,  8'd15,  2'b11}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_clear();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] s);
    sample_vld = 1'b1; sample = s;
    step();
    sample_vld = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R10 reset state
    check("R10", stat_rdata, 2'b00);
    check("R10", {1'b0, irq}, 2'b00);
    rst_n = 1'b1;
    step();
    // R10: reset limits are zero, so 0 sets nothing and 1 is over
    send(8'd0);
    check("R10", stat_rdata, 2'b00);
    send(8'd1);
    check("R10", stat_rdata, 2'b10);
    rd_clear();

    // vector table: R1 R2 R3 R4 R9
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(1'b0, VEC[i][25:10]);
      rd_clear();
      send(VEC[i][9:2]);
      check("R1/R2/R3/R4/R9 vec", stat_rdata, VEC[i][1:0]);
    end
    rd_clear();

    // R4: sample without valid
    wr_reg(1'b0, {8'd100, 8'd50});
    sample = 8'd250; sample_vld = 1'b0;
    step();
    check("R4 no valid", stat_rdata, 2'b00);

    // R5: sticky, read shows flags, then clear
    send(8'd10);
    step(); step();
    check("R5 sticky", stat_rdata, 2'b01);
    stat_rd = 1'b1;
    check("R5 read data", stat_rdata, 2'b01);
    step();
    stat_rd = 1'b0;
    check("R5 cleared", stat_rdata, 2'b00);

    // R6: crossing in the read cycle survives
    stat_rd = 1'b1; sample_vld = 1'b1; sample = 8'd101;
    step();
    stat_rd = 1'b0; sample_vld = 1'b0;
    check("R6 race", stat_rdata, 2'b10);
    rd_clear();

    // R7: interrupt gating
    wr_reg(1'b1, 16'h0002);
    send(8'd10);
    check("R7 masked", {1'b0, irq}, 2'b00);
    send(8'd200);
    check("R7 irq on", {1'b0, irq}, 2'b01);
    step();
    check("R7 irq level", {1'b0, irq}, 2'b01);
    rd_clear();
    check("R7 irq off", {1'b0, irq}, 2'b00);
    wr_reg(1'b1, 16'h0001);
    send(8'd10);
    check("R7 under irq", {1'b0, irq}, 2'b01);
    rd_clear();

    // R8: lockout while converter enabled
    adc_en = 1'b1;
    wr_reg(1'b0, {8'd20, 8'd5});
    send(8'd60);
    check("R8 lock over", stat_rdata, 2'b00);
    send(8'd30);
    check("R8 lock under", stat_rdata, 2'b01);
    rd_clear();
    wr_reg(1'b1, 16'h0000);
    send(8'd30);
    check("R8 ien write", {1'b0, irq}, 2'b00);
    rd_clear();
    adc_en = 1'b0;
    wr_reg(1'b0, {8'd20, 8'd5});
    send(8'd60);
    check("R8 unlocked", stat_rdata, 2'b10);
    rd_clear();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule